// File: doc/BRIEF.md
# Clock Stop and Power-Down Gating

This block sits between a clock generator's source clocks and its output pins. It turns each source into a group of gated copies: processor clocks, memory clocks, two shared-pin memory clocks, stoppable bus clocks, one free-running bus clock, reference clocks, an interrupt-controller reference clock, and two fixed peripheral clocks. Two active-low stop requests can park the processor group or the stoppable bus group. An active-low power-down request parks every group. A pin-function select decides whether the two shared pins carry stop requests or memory clocks.

All gating is glitch-free. Every group's enable is held in a latch that is open only while its source clock is low. A clock therefore stops or resumes only on a low level and never emits a shortened high pulse. Stop requests pass through a per-domain synchronizer whose depth sets each group's latency. Power-down reaches the latch directly, without synchronization. The oscillator-off indication rises once power-down is active and every group has parked.

Top module: `clkstop_ctrl`

## Requirements
- R1: With `mode_i` low, if `cpu_stop_n_i` is sampled low at rising edge n of `cpu_clk_i`, the processor outputs still give full pulses at edges n and n+1 and no rising edge from n+2 on. A release sampled at edge m gives the first pulse at edge m+2.
- R2: With `mode_i` low, if `pci_stop_n_i` is sampled low at rising edge n of `pci_clk_i`, the stoppable bus outputs give a full pulse at edge n and none from n+1 on. A release sampled at edge m gives the first pulse at edge m+1.
- R3: Neither stop request affects the memory, free-running bus, reference, interrupt-controller or peripheral clocks. A processor stop does not affect the bus clocks, and a bus stop does not affect the processor clocks.
- R4: While `pd_n_i` is low, every output is low. A group that is high when power-down arrives finishes its current high phase first. `osc_off_o` is high only while `pd_n_i` is low and every group has parked.
- R5: With `mode_i` high, both stop inputs are ignored, the shared-pin clocks run and `shr_oe_o` is 1. With `mode_i` low, the shared-pin clocks are held low and `shr_oe_o` is 0.
- R6: `cpu_stopped_o` and `pci_stopped_o` are 1 exactly when their group's enable is off. The flag rises during the low phase before the first suppressed edge and falls during the low phase before the first restored edge.
- R7: After a stop or a power-down ends, outputs resume from low on a rising edge of their source, and the first high phase has full width.
- R8: While `rst_n_i` is low, all outputs are low and both stop flags are 1. After release, with all control inputs high, every group runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n_i | input | 1 | Asynchronous active-low reset, released per domain |
| cpu_clk_i | input | 1 | Processor/memory source clock |
| pci_clk_i | input | 1 | Bus source clock |
| ref_clk_i | input | 1 | Reference source clock |
| usb48_clk_i | input | 1 | Fast peripheral source clock |
| usb24_clk_i | input | 1 | Slow peripheral source clock |
| cpu_stop_n_i | input | 1 | Active-low processor stop request (shared pin) |
| pci_stop_n_i | input | 1 | Active-low bus stop request (shared pin) |
| pd_n_i | input | 1 | Asynchronous active-low power-down |
| mode_i | input | 1 | 0: shared pins are stop inputs; 1: shared pins are clock outputs |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| sdram_clk_o | output | N_SDRAM | Gated memory clocks |
| shr_clk_o | output | N_SHR | Memory clocks for the shared pins |
| shr_oe_o | output | 1 | Output enable for the shared pins |
| pci_clk_o | output | N_PCI | Stoppable bus clocks |
| pci_free_clk_o | output | 1 | Free-running bus clock |
| ref_clk_o | output | N_REF | Reference clocks |
| apic_clk_o | output | 1 | Interrupt-controller reference clock |
| usb48_clk_o | output | 1 | Fast peripheral clock |
| usb24_clk_o | output | 1 | Slow peripheral clock |
| cpu_stopped_o | output | 1 | Processor group parked |
| pci_stopped_o | output | 1 | Stoppable bus group parked |
| osc_off_o | output | 1 | Oscillator and VCO may be switched off |

## Verification
Several properties are checked on every edge. Sampled stop requests must reach the processor and bus stop flags within their fixed latency, and mode high must keep the processor group running. Power-down must close every enable latch, and an enable may only reopen when its synchronized request is high. Only the bench scenarios can show analog-like timing at the pins: a pulse already in progress survives power-down, the first pulse after release has full width, the untouched groups keep toggling during each stop, and the oscillator-off flag waits for the slowest group.

// File: rtl/clkstop_pkg.sv
package clkstop_pkg;

  // Synchronizer depths per domain; these set the stop latencies.
  localparam int CPU_SYNC_STAGES = 2;
  localparam int PCI_SYNC_STAGES = 1;
  localparam int OTHER_SYNC_STAGES = 2;
  localparam int RST_SYNC_STAGES = 2;

  // Index of each gated group in the parked-status vector.
  localparam int GRP_CPU   = 0;
  localparam int GRP_SDRAM = 1;
  localparam int GRP_SHR   = 2;
  localparam int GRP_PCI   = 3;
  localparam int GRP_PCIF  = 4;
  localparam int GRP_REF   = 5;
  localparam int GRP_APIC  = 6;
  localparam int GRP_U48   = 7;
  localparam int GRP_U24   = 8;
  localparam int GRP_COUNT = 9;

endpackage

// File: rtl/clkstop_rst_sync.sv
module clkstop_rst_sync #(
  parameter int DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic [DEPTH-1:0] sh_q;
  logic [DEPTH-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[DEPTH-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign rst_n_o = sh_q[DEPTH-1];

endmodule

// File: rtl/clkstop_req_sync.sv
module clkstop_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb begin
        sh_d = d_i;
      end
    end else begin : g_chain
      always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  // Reset parks the group: the request reads as "stopped" until released.
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q_o = sh_q[STAGES-1];

endmodule

// File: rtl/clkstop_gate.sv
module clkstop_gate #(
  parameter int N_OUT       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             pd_n_i,
  input  logic             req_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             stopped_o
);

  import clkstop_pkg::*;

  logic rst_q_n;
  logic run_q;
  logic en_d;
  logic en_lat;

  clkstop_rst_sync #(.DEPTH(RST_SYNC_STAGES)) u_rst (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_q_n)
  );

  clkstop_req_sync #(.STAGES(SYNC_STAGES)) u_req (
    .clk_i   (clk_i),
    .rst_n_i (rst_q_n),
    .d_i     (req_i),
    .q_o     (run_q)
  );

  // Power-down bypasses the synchronizer: it is asynchronous by definition.
  always_comb begin
    en_d = run_q & pd_n_i;
  end

  // Enable latch is open only in the low phase, so the gated clock can only
  // start or stop while low and no high pulse is ever shortened.
  always_latch begin
    if (!clk_i) begin
      en_lat <= en_d;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_fan
      assign clk_o[gi] = clk_i & en_lat;
    end
  endgenerate

  assign stopped_o = ~en_lat;

  AST_PD_CLOSES_GATE: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    !pd_n_i |-> !en_lat); // R4

  AST_REOPEN_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    $rose(en_lat) |-> run_q); // R7

endmodule

// File: rtl/clkstop_ctrl.sv
module clkstop_ctrl #(
  parameter int N_CPU   = 4,
  parameter int N_SDRAM = 6,
  parameter int N_SHR   = 2,
  parameter int N_PCI   = 6,
  parameter int N_REF   = 3
) (
  input  logic               rst_n_i,
  input  logic               cpu_clk_i,
  input  logic               pci_clk_i,
  input  logic               ref_clk_i,
  input  logic               usb48_clk_i,
  input  logic               usb24_clk_i,
  input  logic               cpu_stop_n_i,
  input  logic               pci_stop_n_i,
  input  logic               pd_n_i,
  input  logic               mode_i,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic [N_SHR-1:0]   shr_clk_o,
  output logic               shr_oe_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic               pci_free_clk_o,
  output logic [N_REF-1:0]   ref_clk_o,
  output logic               apic_clk_o,
  output logic               usb48_clk_o,
  output logic               usb24_clk_o,
  output logic               cpu_stopped_o,
  output logic               pci_stopped_o,
  output logic               osc_off_o
);

  import clkstop_pkg::*;

  logic                 cpu_run_req;
  logic                 pci_run_req;
  logic [GRP_COUNT-1:0] grp_off;

  // With mode high the shared pins are outputs, so their stop meaning is void.
  always_comb begin
    cpu_run_req = mode_i | cpu_stop_n_i;
    pci_run_req = mode_i | pci_stop_n_i;
  end

  assign shr_oe_o = mode_i;

  clkstop_gate #(.N_OUT(N_CPU), .SYNC_STAGES(CPU_SYNC_STAGES)) u_cpu (
    .clk_i(cpu_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(cpu_run_req),
    .clk_o(cpu_clk_o), .stopped_o(grp_off[GRP_CPU]));

  clkstop_gate #(.N_OUT(N_SDRAM), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_sdram (
    .clk_i(cpu_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(1'b1),
    .clk_o(sdram_clk_o), .stopped_o(grp_off[GRP_SDRAM]));

  clkstop_gate #(.N_OUT(N_SHR), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_shr (
    .clk_i(cpu_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(mode_i),
    .clk_o(shr_clk_o), .stopped_o(grp_off[GRP_SHR]));

  clkstop_gate #(.N_OUT(N_PCI), .SYNC_STAGES(PCI_SYNC_STAGES)) u_pci (
    .clk_i(pci_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(pci_run_req),
    .clk_o(pci_clk_o), .stopped_o(grp_off[GRP_PCI]));

  clkstop_gate #(.N_OUT(1), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_pcif (
    .clk_i(pci_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(1'b1),
    .clk_o(pci_free_clk_o), .stopped_o(grp_off[GRP_PCIF]));

  clkstop_gate #(.N_OUT(N_REF), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_ref (
    .clk_i(ref_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(1'b1),
    .clk_o(ref_clk_o), .stopped_o(grp_off[GRP_REF]));

  clkstop_gate #(.N_OUT(1), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_apic (
    .clk_i(ref_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(1'b1),
    .clk_o(apic_clk_o), .stopped_o(grp_off[GRP_APIC]));

  clkstop_gate #(.N_OUT(1), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_u48 (
    .clk_i(usb48_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(1'b1),
    .clk_o(usb48_clk_o), .stopped_o(grp_off[GRP_U48]));

  clkstop_gate #(.N_OUT(1), .SYNC_STAGES(OTHER_SYNC_STAGES)) u_u24 (
    .clk_i(usb24_clk_i), .rst_n_i(rst_n_i), .pd_n_i(pd_n_i), .req_i(1'b1),
    .clk_o(usb24_clk_o), .stopped_o(grp_off[GRP_U24]));

  assign cpu_stopped_o = grp_off[GRP_CPU];
  assign pci_stopped_o = grp_off[GRP_PCI];

  // The oscillator may only go off once every group is parked low.
  assign osc_off_o = ~pd_n_i & (&grp_off);

  AST_CPU_STOP_LATENCY: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i, 5) && !$past(mode_i, 2) && !$past(cpu_stop_n_i, 2)) |-> cpu_stopped_o); // R1

  AST_PCI_STOP_LATENCY: assert property (@(posedge pci_clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i, 4) && !$past(mode_i) && !$past(pci_stop_n_i)) |-> pci_stopped_o); // R2

  AST_MODE_BLOCKS_STOP: assert property (@(posedge cpu_clk_i) disable iff (!rst_n_i)
    ($past(rst_n_i, 5) && $past(mode_i, 2) && pd_n_i) |-> !cpu_stopped_o); // R5

endmodule

// File: tb/tb_clkstop_ctrl.sv
`timescale 1ns/100ps
module tb_clkstop_ctrl;

  typedef struct {
    string tag;
    int    sig;
    bit    exp;
    bit    got;
  } chk_t;

  logic rst_n, cpu_clk, pci_clk, ref_clk, u48_clk, u24_clk;
  logic cpu_stop_n, pci_stop_n, pd_n, mode;
  logic [3:0] cpu_o;
  logic [5:0] sdram_o;
  logic [1:0] shr_o;
  logic       shr_oe;
  logic [5:0] pci_o;
  logic       pcif_o;
  logic [2:0] ref_o;
  logic       apic_o, u48_o, u24_o, cpu_stp, pci_stp, osc_off;

  chk_t sbq[$];
  int   n_tests = 0;
  int   n_fail  = 0;
  int   ecnt[9];
  bit   done = 0;

  clkstop_ctrl dut (
    .rst_n_i(rst_n), .cpu_clk_i(cpu_clk), .pci_clk_i(pci_clk), .ref_clk_i(ref_clk),
    .usb48_clk_i(u48_clk), .usb24_clk_i(u24_clk), .cpu_stop_n_i(cpu_stop_n),
    .pci_stop_n_i(pci_stop_n), .pd_n_i(pd_n), .mode_i(mode), .cpu_clk_o(cpu_o),
    .sdram_clk_o(sdram_o), .shr_clk_o(shr_o), .shr_oe_o(shr_oe), .pci_clk_o(pci_o),
    .pci_free_clk_o(pcif_o), .ref_clk_o(ref_o), .apic_clk_o(apic_o),
    .usb48_clk_o(u48_o), .usb24_clk_o(u24_o), .cpu_stopped_o(cpu_stp),
    .pci_stopped_o(pci_stp), .osc_off_o(osc_off));

  initial begin cpu_clk = 0; forever #2 cpu_clk = ~cpu_clk; end
  initial begin pci_clk = 0; forever #4 pci_clk = ~pci_clk; end
  initial begin ref_clk = 0; #0.5; forever #7 ref_clk = ~ref_clk; end
  initial begin u48_clk = 0; #0.5; forever #5 u48_clk = ~u48_clk; end
  initial begin u24_clk = 0; #0.5; forever #10 u24_clk = ~u24_clk; end

  always @(posedge cpu_o[0])   ecnt[0]++;
  always @(posedge sdram_o[0]) ecnt[1]++;
  always @(posedge shr_o[0])   ecnt[2]++;
  always @(posedge pci_o[0])   ecnt[3]++;
  always @(posedge pcif_o)     ecnt[4]++;
  always @(posedge ref_o[0])   ecnt[5]++;
  always @(posedge apic_o)     ecnt[6]++;
  always @(posedge u48_o)      ecnt[7]++;
  always @(posedge u24_o)      ecnt[8]++;

  function automatic bit level(int s);
    case (s)
      0: return cpu_o[0];   1: return sdram_o[0]; 2: return shr_o[0];
      3: return pci_o[0];   4: return pcif_o;     5: return ref_o[0];
      6: return apic_o;     7: return u48_o;      8: return u24_o;
      9: return cpu_stp;    10: return pci_stp;   11: return shr_oe;
      default: return osc_off;
    endcase
  endfunction

  // Scoreboard monitor: pops each expected item and compares.
  initial begin
    forever begin
      chk_t c;
      wait (sbq.size() != 0);
      c = sbq.pop_front();
      n_tests++;
      if (c.got !== c.exp) begin
        n_fail++;
        $display("FAIL %s: got %0d expected %0d", c.tag, c.got, c.exp);
      end
    end
  end

  task automatic cstep(); @(posedge cpu_clk); #1; endtask
  task automatic pstep(); @(posedge pci_clk); #1; endtask

  task automatic exp_lvl(string tag, int sig, bit e);
    chk_t c;
    c.tag = tag; c.sig = sig; c.exp = e; c.got = level(sig);
    sbq.push_back(c);
  endtask

  task automatic exp_act(string tag, int sig, bit e);
    chk_t c;
    ecnt[sig] = 0;
    #61;
    c.tag = tag; c.sig = sig; c.exp = e; c.got = (ecnt[sig] > 0);
    sbq.push_back(c);
  endtask

  task automatic finish_run();
    #5;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #100000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1; cpu_stop_n = 1; pci_stop_n = 1; pd_n = 1; mode = 1;
    #1 rst_n = 0;
    #14;
    exp_lvl("R8 cpu low in reset", 0, 0);
    exp_lvl("R8 cpu flag in reset", 9, 1);
    exp_lvl("R8 pci flag in reset", 10, 1);
    #2 rst_n = 1;
    repeat (10) cstep();
    exp_act("R8 cpu runs", 0, 1);
    exp_act("R8 sdram runs", 1, 1);
    exp_act("R8 ref runs", 5, 1);
    exp_act("R8 usb24 runs", 8, 1);
    exp_lvl("R4 osc on", 12, 0);

    // Mode high: stop pins ignored, shared pins clock out.
    cpu_stop_n = 0; pci_stop_n = 0;
    repeat (6) cstep();
    exp_act("R5 cpu ignores stop", 0, 1);
    exp_act("R5 pci ignores stop", 3, 1);
    exp_act("R5 shared clocks run", 2, 1);
    exp_lvl("R5 shared oe high", 11, 1);
    cpu_stop_n = 1; pci_stop_n = 1;
    cstep(); mode = 0;
    repeat (6) cstep();
    exp_act("R5 shared clocks held", 2, 0);
    exp_lvl("R5 shared oe low", 11, 0);

    // Processor stop latency (R1) and flag timing (R6).
    cstep(); cpu_stop_n = 0;
    cstep(); exp_lvl("R1 pulse n", 0, 1);
    cstep(); exp_lvl("R1 pulse n+1", 0, 1); exp_lvl("R6 cpu flag still 0", 9, 0);
    cstep(); exp_lvl("R1 no edge n+2", 0, 0); exp_lvl("R6 cpu flag 1", 9, 1);
    exp_act("R1 cpu parked", 0, 0);
    exp_act("R3 sdram during cpu stop", 1, 1);
    exp_act("R3 pci during cpu stop", 3, 1);
    exp_act("R3 apic during cpu stop", 6, 1);
    exp_act("R3 usb48 during cpu stop", 7, 1);
    cstep(); cpu_stop_n = 1;
    cstep(); exp_lvl("R1 still low m", 0, 0);
    cstep(); exp_lvl("R1 still low m+1", 0, 0);
    cstep(); exp_lvl("R7 cpu first pulse", 0, 1); exp_lvl("R6 cpu flag 0", 9, 0);
    #0.8 exp_lvl("R7 cpu pulse full width", 0, 1);

    // Bus stop latency (R2).
    pstep(); pci_stop_n = 0;
    pstep(); exp_lvl("R2 pulse n", 3, 1);
    pstep(); exp_lvl("R2 no edge n+1", 3, 0); exp_lvl("R6 pci flag 1", 10, 1);
    exp_act("R2 pci parked", 3, 0);
    exp_act("R3 free pci runs", 4, 1);
    exp_act("R3 cpu during pci stop", 0, 1);
    exp_act("R3 ref during pci stop", 5, 1);
    pstep(); pci_stop_n = 1;
    pstep(); exp_lvl("R2 still low m", 3, 0);
    pstep(); exp_lvl("R2 first pulse m+1", 3, 1); exp_lvl("R6 pci flag 0", 10, 0);

    // Power-down in the middle of a high phase.
    cstep(); pd_n = 0;
    #0.5 exp_lvl("R4 current pulse kept", 0, 1);
    #1 exp_lvl("R4 cpu low after cycle", 0, 0);
    #40;
    exp_lvl("R4 osc off", 12, 1);
    exp_act("R4 cpu off", 0, 0);
    exp_act("R4 free pci off", 4, 0);
    exp_act("R4 sdram off", 1, 0);
    exp_act("R4 usb24 off", 8, 0);
    exp_lvl("R4 ref low", 5, 0);
    cstep(); pd_n = 1;
    #0.1 exp_lvl("R4 osc back on", 12, 0);
    cstep(); exp_lvl("R7 cpu restarts", 0, 1);
    #0.8 exp_lvl("R7 restart full width", 0, 1);
    exp_act("R7 ref restarts", 5, 1);

    done = 1;
    wait (sbq.size() == 0);
    finish_run();
  end

endmodule